// File: doc/BRIEF.md
# Packed-BCD Decimal Adjust Unit

This block repairs an 8-bit accumulator value produced by a plain binary addition or subtraction of two packed-BCD bytes, so that the value becomes a valid two-digit packed-BCD number. It takes the raw accumulator together with the carry, half-carry and subtract flags left by that arithmetic step. It returns the corrected byte and a freshly built flag byte.

The correction depends on the subtract flag. After an add, the block adds a per-digit offset of 6. After a subtract, it removes that offset. The same digit-range tests choose which digits need fixing in both modes. Any input combination yields a deterministic result, including combinations that no legal BCD operation can produce.

The unit takes one operand per cycle. Every result appears exactly one clock later, qualified by a valid strobe. The arithmetic that precedes the adjustment is not part of this block.

Top module: `dadj_unit`

## Requirements
- R1: `out_valid` is high in exactly those cycles that follow a rising clock edge at which `in_valid` was sampled high. The corrected value and flags appear with that same one-cycle latency.
- R2: With `sub_in`=0, the low-digit correction is 06h when the low nibble exceeds 9 or `half_in`=1. The high-digit correction is 60h when `carry_in`=1 or the accumulator exceeds 99h. The selected corrections are summed and added to the accumulator modulo 256.
- R3: With `sub_in`=0, and with none of the R2 conditions true, the accumulator passes through unchanged and the carry flag is 0.
- R4: With `sub_in`=1, the same R2 conditions pick the corrections, and they are subtracted modulo 256. Subtracting 06h, 60h or 66h is the same as adding FAh, A0h or 9Ah.
- R5: The carry flag out equals `carry_in` OR (accumulator > 99h), in both modes.
- R6: The half-carry flag out is the carry (add) or borrow (subtract) out of bit 3 caused by the correction. It is 0 when no low-digit correction applies.
- R7: The sign flag equals bit 7 of the result. The zero flag is 1 exactly when the result is 00h. The parity flag is 1 when the result holds an even number of 1 bits.
- R8: The flag byte is laid out as sign at bit 7, zero at bit 6, half-carry at bit 4, parity at bit 2, subtract at bit 1 and carry at bit 0. Bits 5 and 3 read 0. The subtract bit repeats `sub_in` unchanged.
- R9: In a cycle where `in_valid` is sampled low, `acc_out` and `flags_out` keep their previous values, whatever the data inputs carry.
- R10: While `rst_n` is low, `out_valid`, `acc_out` and `flags_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand present this cycle |
| acc_in | input | 8 | Raw accumulator after binary add/subtract |
| carry_in | input | 1 | Carry flag from the preceding operation |
| half_in | input | 1 | Half-carry flag from the preceding operation |
| sub_in | input | 1 | 1 when the preceding operation was a subtract |
| out_valid | output | 1 | Result registered this cycle |
| acc_out | output | 8 | Corrected packed-BCD accumulator |
| flags_out | output | 8 | Flag byte, layout per R8 |

## Verification
On every cycle, the assertions check the following properties:
- the valid strobe timing;
- the hold of the outputs when no operand arrives;
- that an incoming carry is never lost;
- the pass-through of the subtract bit and the reserved zero bits;
- the agreement of sign and zero with the registered result;
- the absence of a half-carry where no low-digit fix applies;
- that an add which wraps past FFh always reports carry.

The exact corrected byte, the parity and the half-carry for each of the 256 accumulator values under all eight flag combinations can only be shown by the bench's full sweep. That sweep also interleaves idle cycles with changing data to expose any leak into held outputs.

// File: rtl/dadj_pkg.sv
package dadj_pkg;
  localparam int NIB_W   = 4;
  localparam int DIGITS  = 2;
  localparam int DATA_W  = NIB_W * DIGITS;
  localparam int FIX_VAL = 6;
  localparam int LIMIT   = 9;

  // flag byte bit positions
  localparam int F_SIGN  = 7;
  localparam int F_ZERO  = 6;
  localparam int F_HALF  = 4;
  localparam int F_PAR   = 2;
  localparam int F_SUB   = 1;
  localparam int F_CARRY = 0;

  typedef logic [DATA_W-1:0] word_t;
  typedef logic [NIB_W-1:0]  nib_t;

  typedef struct packed {
    logic sign;
    logic zero;
    logic half;
    logic parity;
    logic sub;
    logic carry;
  } flag_set_t;

  function automatic logic nib_over(input nib_t n);
    return n > nib_t'(LIMIT);
  endfunction

  function automatic logic [NIB_W:0] nib_sum(input nib_t a, input nib_t b, input logic cin);
    return {1'b0, a} + {1'b0, b} + {{NIB_W{1'b0}}, cin};
  endfunction

  function automatic logic even_ones(input word_t w);
    return ~^w;
  endfunction

  function automatic word_t pack_flags(input flag_set_t f);
    word_t w;
    w          = '0;
    w[F_SIGN]  = f.sign;
    w[F_ZERO]  = f.zero;
    w[F_HALF]  = f.half;
    w[F_PAR]   = f.parity;
    w[F_SUB]   = f.sub;
    w[F_CARRY] = f.carry;
    return w;
  endfunction
endpackage

// File: rtl/dadj_detect.sv
module dadj_detect
  import dadj_pkg::*;
(
  input  word_t             acc,
  input  logic              carry_in,
  input  logic              half_in,
  output logic [DIGITS-1:0] fix,
  output logic              carry_out
);
  nib_t lo_nib;
  nib_t hi_nib;
  logic above_limit;

  assign lo_nib = acc[NIB_W-1:0];
  assign hi_nib = acc[DATA_W-1:NIB_W];

  // accumulator exceeds the largest two-digit BCD value
  assign above_limit = nib_over(hi_nib) |
                       ((hi_nib == nib_t'(LIMIT)) & nib_over(lo_nib));

  assign fix[0]        = nib_over(lo_nib) | half_in;
  assign fix[DIGITS-1] = carry_in | above_limit;
  assign carry_out     = fix[DIGITS-1];
endmodule

// File: rtl/dadj_apply.sv
module dadj_apply
  import dadj_pkg::*;
(
  input  word_t             acc,
  input  logic [DIGITS-1:0] fix,
  input  logic              sub,
  output word_t             result,
  output logic              half_out,
  output logic              top_wrap
);
  logic [DIGITS:0] chain;

  // subtract as acc + ~offset + 1, one nibble at a time
  assign chain[0] = sub;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    nib_t           corr;
    nib_t           opnd;
    logic [NIB_W:0] s;
    assign corr = fix[g] ? nib_t'(FIX_VAL) : '0;
    assign opnd = sub ? ~corr : corr;
    assign s    = nib_sum(acc[g*NIB_W +: NIB_W], opnd, chain[g]);
    assign result[g*NIB_W +: NIB_W] = s[NIB_W-1:0];
    assign chain[g+1] = s[NIB_W];
  end

  // borrow is the inverse of the two's-complement carry
  assign half_out = chain[1] ^ sub;
  assign top_wrap = chain[DIGITS] ^ sub;
endmodule

// File: rtl/dadj_flags.sv
module dadj_flags
  import dadj_pkg::*;
(
  input  word_t result,
  input  logic  half,
  input  logic  sub,
  input  logic  carry,
  output word_t flags
);
  flag_set_t fs;

  assign fs.sign   = result[DATA_W-1];
  assign fs.zero   = (result == '0);
  assign fs.half   = half;
  assign fs.parity = even_ones(result);
  assign fs.sub    = sub;
  assign fs.carry  = carry;
  assign flags     = pack_flags(fs);
endmodule

// File: rtl/dadj_unit.sv
module dadj_unit
  import dadj_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] acc_in,
  input  logic       carry_in,
  input  logic       half_in,
  input  logic       sub_in,
  output logic       out_valid,
  output logic [7:0] acc_out,
  output logic [7:0] flags_out
);
  logic [DIGITS-1:0] fix_sel;
  logic              carry_fix;
  word_t             corrected;
  logic              half_fix;
  logic              wrap_fix;
  word_t             flag_word;

  dadj_detect u_detect (
    .acc       (acc_in),
    .carry_in  (carry_in),
    .half_in   (half_in),
    .fix       (fix_sel),
    .carry_out (carry_fix)
  );

  dadj_apply u_apply (
    .acc      (acc_in),
    .fix      (fix_sel),
    .sub      (sub_in),
    .result   (corrected),
    .half_out (half_fix),
    .top_wrap (wrap_fix)
  );

  dadj_flags u_flags (
    .result (corrected),
    .half   (half_fix),
    .sub    (sub_in),
    .carry  (carry_fix),
    .flags  (flag_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      acc_out   <= '0;
      flags_out <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        acc_out   <= corrected;
        flags_out <= flag_word;
      end
    end
  end

  // R5: an add that wraps past the top must have taken the high correction
  always_comb begin
    if (rst_n && in_valid && !sub_in && wrap_fix)
      p_wrap_carry_r5: assert (carry_fix);
  end

  p_valid_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(acc_out) && $stable(flags_out)));
  p_carry_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && carry_in) |=> flags_out[F_CARRY]);
  p_sub_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (flags_out[F_SUB] == $past(sub_in)));
  p_spare_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (!flags_out[5] && !flags_out[3]));
  p_zero_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (flags_out[F_ZERO] == (acc_out == 8'h00)));
  p_sign_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (flags_out[F_SIGN] == acc_out[7]));
  p_sub_no_half_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sub_in && !half_in) |=> !flags_out[F_HALF]);
  p_add_no_half_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !sub_in && (acc_in[3:0] <= 4'd9)) |=> !flags_out[F_HALF]);
endmodule

// File: tb/dadj_unit_tb_top.sv
module dadj_unit_tb_top;
  localparam int CLK_PERIOD      = 10;
  localparam int WATCHDOG_CYCLES = 50000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] acc_in = 8'h00;
  logic       carry_in = 1'b0;
  logic       half_in = 1'b0;
  logic       sub_in = 1'b0;
  logic       out_valid;
  logic [7:0] acc_out;
  logic [7:0] flags_out;

  int    n_checks = 0;
  int    n_fails  = 0;
  bit    finished = 0;
  bit    exp_v    = 0;
  int    exp_acc  = 0;
  int    exp_flg  = 0;
  string exp_tag  = "R9";

  always #(CLK_PERIOD/2) clk = ~clk;

  dadj_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .acc_in(acc_in),
    .carry_in(carry_in), .half_in(half_in), .sub_in(sub_in),
    .out_valid(out_valid), .acc_out(acc_out), .flags_out(flags_out)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference built from the requirement text
  task automatic model(input int a, input bit c, input bit h, input bit n);
    int lo, hi, off, r, ones;
    bit fl, fh, hout, par;
    lo = a % 16;
    hi = a / 16;
    fl = (lo > 9) || h;
    fh = c || (a > 153);
    off = (fl ? 6 : 0) + (fh ? 96 : 0);
    r = n ? ((a - off + 256) % 256) : ((a + off) % 256);
    hout = fl && (n ? (lo < 6) : (lo > 9));
    ones = 0;
    for (int k = 0; k < 8; k++) ones += (r >> k) & 1;
    par = (ones % 2) == 0;
    exp_acc = r;
    exp_flg = ((r / 128) << 7) | (int'(r == 0) << 6) | (int'(hout) << 4) |
              (int'(par) << 2) | (int'(n) << 1) | int'(fh);
    if (n) exp_tag = "R4";
    else if (!fl && !fh) exp_tag = "R3";
    else exp_tag = "R2";
    if (hi > 15) exp_tag = "R2";
  endtask

  task automatic compare();
    string dt;
    chk("R1", "out_valid", int'(out_valid), int'(exp_v));
    dt = exp_v ? exp_tag : "R9";
    chk(dt, "result", int'(acc_out), exp_acc);
    chk(exp_v ? "R5" : "R9", "carry", int'(flags_out[0]), exp_flg & 1);
    chk(exp_v ? "R6" : "R9", "half", int'(flags_out[4]), (exp_flg >> 4) & 1);
    chk(exp_v ? "R7" : "R9", "sign/zero/parity",
        int'({flags_out[7], flags_out[6], flags_out[2]}),
        (((exp_flg >> 7) & 1) << 2) | (((exp_flg >> 6) & 1) << 1) | ((exp_flg >> 2) & 1));
    chk(exp_v ? "R8" : "R9", "sub/spare bits",
        int'({flags_out[5], flags_out[3], flags_out[1]}),
        (((exp_flg >> 5) & 1) << 2) | (((exp_flg >> 3) & 1) << 1) | ((exp_flg >> 1) & 1));
  endtask

  task automatic step(input bit v, input int a, input bit c, input bit h, input bit n);
    @(negedge clk);
    compare();
    in_valid = v;
    acc_in   = a[7:0];
    carry_in = c;
    half_in  = h;
    sub_in   = n;
    exp_v    = v;
    if (v) model(a, c, h, n);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "out_valid in reset", int'(out_valid), 0);
    chk("R10", "acc_out in reset", int'(acc_out), 0);
    chk("R10", "flags_out in reset", int'(flags_out), 0);
    rst_n = 1'b1;
    exp_v = 0; exp_acc = 0; exp_flg = 0;
    for (int idx = 0; idx < 2048; idx++) begin
      if (idx % 7 == 3)
        // R9: idle cycle with changing data that must be ignored
        step(0, (idx * 37) % 256, idx[0], idx[1], idx[2]);
      step(1, idx % 256, idx[8], idx[9], idx[10]);
    end
    step(0, 8'h5A, 1, 1, 1);
    step(0, 8'hA5, 0, 0, 0);
    @(negedge clk);
    compare();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule